// File: doc/BRIEF.md
# Coded-Exposure Frame Sequencer

This block times one frame of a dual-tap coded-exposure image sensor. On a start request it runs a fixed series of phases: a global clear in which the exposure gate and both tap resets are driven high, a controlled release, a configurable number of coded subframes, and a row-by-row readout. Every subframe opens with a short code-update window. In that window the exposure gate is held low and a single global strobe tells the pixel array to move its preloaded code into the active latch. A programmable exposure interval follows, with the gate high.

The subframe count, the exposure length in clock cycles and the number of rows to read are sampled once, when a frame is accepted. The inputs may change freely while a frame runs. A one-cycle done pulse marks the end of the readout. Fixed timing constants are parameters: the clear length, the update-window length and the dwell per row.

Top module: `cexp_frame_seq`

## Requirements
- R1: After reset every output is low: exposure gate, both tap resets, code strobe, row select, busy and done.
- R2: A start request seen while idle begins a frame. For RESET_CYC cycles, starting in the cycle after the sampling edge, the exposure gate and both tap resets are high, and busy rises with them.
- R3: The clear ends with exactly one cycle in which the exposure gate is low and both tap resets are still high. The resets go low only after that cycle, so the gate always falls before the resets.
- R4: Each subframe begins with an UPD_CYC-cycle update window (UPD_CYC of at least 2) in which the exposure gate is low. The code strobe is high only in the first cycle of each window, so it always comes at least one cycle before the gate rises.
- R5: Each exposure interval keeps the gate high for the sampled exposure length in cycles, and a sampled length of 0 acts as 1.
- R6: A frame contains exactly the sampled number of subframes, and a sampled count of 0 acts as 1.
- R7: During readout the gate and both resets are low. The row select is one-hot, starting at bit 0 and moving one bit up every ROW_CYC cycles. The number of rows read is the sampled row count; 0 acts as 1 and values above ROWS_MAX act as ROWS_MAX.
- R8: In the cycle right after the last row is deselected, done is high for exactly one cycle and busy is low. Busy stays high from the first clear cycle through the last readout cycle.
- R9: Configuration inputs are sampled only when a frame is accepted. A start request or configuration change during a frame has no effect on that frame.
- R10: Outside update windows the code strobe stays low, and outside readout the row select is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request, taken only while idle |
| cfg_subframes_i | input | SUB_W | Subframes per frame |
| cfg_exp_len_i | input | EXP_W | Exposure interval length in cycles |
| cfg_rows_i | input | ROW_W | Rows to read out |
| expose_o | output | 1 | Global exposure gate |
| tap1_rst_o | output | 1 | Reset for tap 1 |
| tap2_rst_o | output | 1 | Reset for tap 2 |
| code_load_o | output | 1 | One-cycle global code-transfer strobe |
| row_sel_o | output | ROWS_MAX | One-hot readout row select |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situations to reach are the ones where the inputs try to disturb a running frame: a second start request in the middle of exposure, and configuration values that change after a frame has been accepted. The stimulus queues the full expected frame at the moment start is accepted. It then drives a new start pulse and different configuration values partway through, so any resampling shows up as a miscompare against the queued vectors. The boundary values (zero subframes, zero exposure length, zero rows and a row count beyond the array) are each applied to a full frame, so the clamping rules are checked cycle by cycle.

// File: rtl/cexp_pkg.sv
`timescale 1ns/1ps
package cexp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_RELEASE,
    PH_UPDATE,
    PH_EXPOSE,
    PH_READ
  } phase_t;
endpackage

// File: rtl/cexp_dwell_timer.sv
`timescale 1ns/1ps
// Down counter: loaded with (length - 1) when a phase is entered.
// expired_o is high in the last cycle of that phase.
module cexp_dwell_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cexp_row_walker.sv
`timescale 1ns/1ps
// One-hot readout row pointer, registered.
module cexp_row_walker #(
  parameter int ROWS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            first_i,
  input  logic            step_i,
  input  logic            clear_i,
  output logic [ROWS-1:0] sel_o
);
  always_ff @(posedge clk) begin
    if (rst)          sel_o <= '0;
    else if (first_i) sel_o <= {{(ROWS-1){1'b0}}, 1'b1};
    else if (clear_i) sel_o <= '0;
    else if (step_i)  sel_o <= {sel_o[ROWS-2:0], 1'b0};
  end
endmodule

// File: rtl/cexp_frame_seq.sv
`timescale 1ns/1ps
module cexp_frame_seq
  import cexp_pkg::*;
#(
  parameter int SUB_W     = 4,
  parameter int EXP_W     = 16,
  parameter int ROWS_MAX  = 16,
  parameter int RESET_CYC = 4,
  parameter int UPD_CYC   = 3,
  parameter int ROW_CYC   = 2,
  localparam int ROW_W    = $clog2(ROWS_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SUB_W-1:0]    cfg_subframes_i,
  input  logic [EXP_W-1:0]    cfg_exp_len_i,
  input  logic [ROW_W-1:0]    cfg_rows_i,
  output logic                expose_o,
  output logic                tap1_rst_o,
  output logic                tap2_rst_o,
  output logic                code_load_o,
  output logic [ROWS_MAX-1:0] row_sel_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int TW = EXP_W;

  phase_t state_q, state_d;
  logic [SUB_W-1:0] n_q, sub_q, sub_d;
  logic [EXP_W-1:0] len_q;
  logic [ROW_W-1:0] rows_q, row_q, row_d;
  logic             tmr_load, tmr_done;
  logic [TW-1:0]    tmr_val;
  logic             take;
  logic             clr_q;

  assign take = (state_q == PH_IDLE) && start_i;

  // R9: configuration captured only on frame acceptance, with clamping
  always_ff @(posedge clk) begin
    if (rst) begin
      n_q    <= SUB_W'(1);
      len_q  <= EXP_W'(1);
      rows_q <= ROW_W'(1);
    end else if (take) begin
      n_q   <= (cfg_subframes_i == '0) ? SUB_W'(1) : cfg_subframes_i;
      len_q <= (cfg_exp_len_i == '0) ? EXP_W'(1) : cfg_exp_len_i;
      if (cfg_rows_i == '0)                      rows_q <= ROW_W'(1);
      else if (cfg_rows_i > ROW_W'(ROWS_MAX))    rows_q <= ROW_W'(ROWS_MAX);
      else                                       rows_q <= cfg_rows_i;
    end
  end

  always_comb begin
    state_d  = state_q;
    sub_d    = sub_q;
    row_d    = row_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      PH_IDLE: if (start_i) begin
        state_d  = PH_RESET;
        tmr_load = 1'b1;
        tmr_val  = TW'(RESET_CYC - 1);
      end
      PH_RESET: if (tmr_done) state_d = PH_RELEASE;
      PH_RELEASE: begin
        state_d  = PH_UPDATE;
        sub_d    = '0;
        tmr_load = 1'b1;
        tmr_val  = TW'(UPD_CYC - 1);
      end
      PH_UPDATE: if (tmr_done) begin
        state_d  = PH_EXPOSE;
        tmr_load = 1'b1;
        tmr_val  = len_q - 1'b1;
      end
      PH_EXPOSE: if (tmr_done) begin
        tmr_load = 1'b1;
        if (sub_q == n_q - 1'b1) begin
          state_d = PH_READ;
          row_d   = '0;
          tmr_val = TW'(ROW_CYC - 1);
        end else begin
          state_d = PH_UPDATE;
          sub_d   = sub_q + 1'b1;
          tmr_val = TW'(UPD_CYC - 1);
        end
      end
      PH_READ: if (tmr_done) begin
        if (row_q == rows_q - 1'b1) begin
          state_d = PH_IDLE;
        end else begin
          row_d    = row_q + 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(ROW_CYC - 1);
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      sub_q   <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      row_q   <= row_d;
    end
  end

  cexp_dwell_timer #(.W(TW)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_done)
  );

  cexp_row_walker #(.ROWS(ROWS_MAX)) rows_i (
    .clk     (clk),
    .rst     (rst),
    .first_i ((state_d == PH_READ) && (state_q != PH_READ)),
    .step_i  ((state_q == PH_READ) && (state_d == PH_READ) && tmr_done),
    .clear_i (state_d != PH_READ),
    .sel_o   (row_sel_o)
  );

  // Registered outputs decoded from the next phase
  always_ff @(posedge clk) begin
    if (rst) begin
      expose_o    <= 1'b0;
      clr_q       <= 1'b0;
      code_load_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      expose_o    <= (state_d == PH_RESET) || (state_d == PH_EXPOSE);
      clr_q       <= (state_d == PH_RESET) || (state_d == PH_RELEASE);
      code_load_o <= (state_d == PH_UPDATE) && (state_q != PH_UPDATE);
      busy_o      <= (state_d != PH_IDLE);
      done_o      <= (state_q == PH_READ) && (state_d == PH_IDLE);
    end
  end

  assign tap1_rst_o = clr_q;
  assign tap2_rst_o = clr_q;
endmodule

// File: rtl/cexp_frame_seq_chk.sv
`timescale 1ns/1ps
module cexp_frame_seq_chk #(
  parameter int ROWS_MAX = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                expose_o,
  input logic                tap1_rst_o,
  input logic                tap2_rst_o,
  input logic                code_load_o,
  input logic [ROWS_MAX-1:0] row_sel_o,
  input logic                busy_o,
  input logic                done_o
);
  // R2: a frame opens with the clear phase
  a_r2_frame_opens_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (expose_o && tap1_rst_o && tap2_rst_o));

  // R3: gate falls while resets are still held
  a_r3_gate_before_reset: assert property (@(posedge clk) disable iff (rst)
    ($fell(expose_o) && $past(tap1_rst_o)) |-> tap1_rst_o);

  // R3: resets are released only after a cycle with the gate low
  a_r3_reset_release_dark: assert property (@(posedge clk) disable iff (rst)
    $fell(tap1_rst_o) |-> (!expose_o && !$past(expose_o)));

  // R4: strobe only with the gate low
  a_r4_load_dark: assert property (@(posedge clk) disable iff (rst)
    code_load_o |-> !expose_o);

  // R4: gate stays low in the cycle after the strobe
  a_r4_load_lead: assert property (@(posedge clk) disable iff (rst)
    code_load_o |=> (!expose_o && !code_load_o));

  // R7: one-hot rows, and readout is dark with resets released
  a_r7_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel_o));

  a_r7_read_dark: assert property (@(posedge clk) disable iff (rst)
    (|row_sel_o) |-> (!expose_o && !tap1_rst_o && !tap2_rst_o && busy_o));

  // R8: done is a single cycle outside the busy window
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)) ##1 !done_o);

  // R10: strobe only inside a frame
  a_r10_load_in_frame: assert property (@(posedge clk) disable iff (rst)
    code_load_o |-> (busy_o && !tap1_rst_o && (row_sel_o == '0)));
endmodule

bind cexp_frame_seq cexp_frame_seq_chk #(.ROWS_MAX(ROWS_MAX)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .expose_o    (expose_o),
  .tap1_rst_o  (tap1_rst_o),
  .tap2_rst_o  (tap2_rst_o),
  .code_load_o (code_load_o),
  .row_sel_o   (row_sel_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/cexp_frame_seq_tb_top.sv
`timescale 1ns/1ps
module cexp_frame_seq_tb_top;
  localparam int SUB_W = 4, EXP_W = 16, ROWS_MAX = 16;
  localparam int RC = 4, UC = 3, RW = 2;
  localparam int ROW_W = $clog2(ROWS_MAX + 1);

  typedef struct packed {
    logic                ex;
    logic                rs;
    logic                ld;
    logic                bsy;
    logic                dn;
    logic [ROWS_MAX-1:0] rows;
  } vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [SUB_W-1:0] cfg_subframes_i = '0;
  logic [EXP_W-1:0] cfg_exp_len_i = '0;
  logic [ROW_W-1:0] cfg_rows_i = '0;
  logic expose_o, tap1_rst_o, tap2_rst_o, code_load_o, busy_o, done_o;
  logic [ROWS_MAX-1:0] row_sel_o;

  int   vectors = 0;
  int   miscompares = 0;
  bit   ended = 0;
  vec_t exp_q[$];

  always #2 clk = ~clk;

  cexp_frame_seq #(
    .SUB_W(SUB_W), .EXP_W(EXP_W), .ROWS_MAX(ROWS_MAX),
    .RESET_CYC(RC), .UPD_CYC(UC), .ROW_CYC(RW)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cfg_subframes_i(cfg_subframes_i), .cfg_exp_len_i(cfg_exp_len_i),
    .cfg_rows_i(cfg_rows_i), .expose_o(expose_o), .tap1_rst_o(tap1_rst_o),
    .tap2_rst_o(tap2_rst_o), .code_load_o(code_load_o),
    .row_sel_o(row_sel_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
    end
  endtask

  task automatic compare(input vec_t e);
    vectors++;
    chk("R5", "expose", int'(expose_o), int'(e.ex));
    chk("R3", "tap1_rst", int'(tap1_rst_o), int'(e.rs));
    chk("R3", "tap2_rst", int'(tap2_rst_o), int'(e.rs));
    chk("R4", "code_load", int'(code_load_o), int'(e.ld));
    chk("R8", "busy", int'(busy_o), int'(e.bsy));
    chk("R8", "done", int'(done_o), int'(e.dn));
    chk("R7", "row_sel", int'(row_sel_o), int'(e.rows));
  endtask

  // Monitor: one queued vector per cycle, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  // Driver: accept a frame, queue its whole expected trace (R2, R6, R10)
  task automatic run_frame(input int n, input int l, input int r, input bit disturb);
    int nn, ll, rr, rb, d;
    @(negedge clk);
    cfg_subframes_i = SUB_W'(n);
    cfg_exp_len_i   = EXP_W'(l);
    cfg_rows_i      = ROW_W'(r);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    nn = (n == 0) ? 1 : n;                        // R6
    ll = (l == 0) ? 1 : l;                        // R5
    rr = (r == 0) ? 1 : ((r > ROWS_MAX) ? ROWS_MAX : r);  // R7
    rb = RC + 1 + nn * (UC + ll);
    d  = rb + rr * RW;
    for (int c = 0; c <= d + 2; c++) begin
      vec_t v;
      v = '0;
      if (c < RC) begin v.ex = 1; v.rs = 1; v.bsy = 1; end       // R2
      else if (c == RC) begin v.rs = 1; v.bsy = 1; end            // R3
      else if (c < rb) begin
        int m;
        m = (c - RC - 1) % (UC + ll);
        v.bsy = 1;
        if (m == 0) v.ld = 1;                                     // R4, R10
        if (m >= UC) v.ex = 1;                                    // R5
      end else if (c < d) begin
        v.bsy = 1;
        v.rows = ROWS_MAX'(1) << ((c - rb) / RW);                 // R7
      end else if (c == d) v.dn = 1;                              // R8
      exp_q.push_back(v);
    end
    if (disturb) begin
      // R9: new config and a second start mid-frame must not matter
      cfg_subframes_i = SUB_W'(1);
      cfg_exp_len_i   = EXP_W'(9);
      cfg_rows_i      = ROW_W'(2);
      repeat (RC + 6) @(negedge clk);
      start_i = 1'b1;
      @(posedge clk);
      #1 start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state at the ports
    @(negedge clk);
    compare('0);
    @(negedge clk);
    compare('0);
    run_frame(4, 5, 6, 0);     // typical four-subframe frame
    run_frame(1, 1, 1, 0);     // shortest legal frame
    run_frame(0, 0, 0, 0);     // zero settings clamp to one
    run_frame(3, 2, 20, 1);    // row clamp plus mid-frame disturbance (R9)
    run_frame(15, 3, 16, 0);   // max subframes and full array
    run_frame(2, 7, 5, 1);     // R9 again with other values
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      miscompares++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule